// File: doc/BRIEF.md
# Integrate-and-Fire Network with Global Inhibition

This block is a discrete-time model of a small population of leaky integrate-and-fire cells. Together the cells act as one oversampling 1-bit converter. Each clock cycle with `step_i` high is one time step. In that step every cell takes the same digital sample, which is the sum of a steady term and a varying term. Each cell leaks a fixed fraction of its signed state and adds the sample scaled by its own gain. It also subtracts a fixed inhibition amount once for every *other* cell that fired in the previous step.

A cell whose state reaches the threshold emits a spike for that step and restarts from zero. The mutual inhibition spreads the firings out evenly in time. The block reports two results for each step: the vector of spikes and the number of cells that fired. A cascade switch changes the report so that any number of coincident spikes counts as one event. In that mode the block also drives a programmable stage gain on an output, which is meant for the varying input of a following stage. Filtering and decimation of the spike stream are done outside the block.

Top module: `ifn_net`

## Requirements
- R1: A synchronous reset clears every cell state and the spike vector to zero. While reset is held, `vld_o`, `cnt_o` and `drive_o` are all 0.
- R2: Step timing:
  - The result of a step sampled at a clock edge appears on the outputs after that edge, and `vld_o` is 1 for exactly that cycle.
  - In a cycle with `step_i` low, the states and `spk_o` hold and `vld_o` is 0.
- R3: In a step, cell i computes a new value from its state v and the sample x = `base_i` + `var_i` (both signed, added at IW+1 bits). The new value is v − (v >>> S) + g_i·x − K·m_i.
- R4: If the new value is at least TH, bit i of `spk_o` is 1 for that step and the state becomes 0. Otherwise the bit is 0 and the state takes the new value.
- R5: m_i is the number of cells other than i that fired in the previous step. Inhibition from a firing therefore acts in exactly one following step.
- R6: A new value below −2^(W−1) is clamped to −2^(W−1), so repeated inhibition cannot wrap a state to a positive value.
- R7: The gain of cell i (bit i of `spk_o`) is g_i = GAIN_BASE + floor(GAIN_BASE·i / (2·(N−1))). The gains therefore spread from 1 to 1.5 times the base.
- R8: With `casc_en_i` low, `cnt_o` equals the number of set bits in `spk_o`, and `drive_o` is 0.
- R9: With `casc_en_i` high:
  - `cnt_o` is 1 when any bit of `spk_o` is set and 0 otherwise.
  - `drive_o` equals `stage_gain_i` when any bit is set and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance the network by one time step |
| base_i | input | IW | Steady part of the shared sample, signed |
| var_i | input | IW | Varying part of the shared sample, signed |
| casc_en_i | input | 1 | Report coincident spikes as one event |
| stage_gain_i | input | IW | Signed value driven to the next stage on an event |
| spk_o | output | N | Spike of each cell for the last step |
| cnt_o | output | $clog2(N+1) | Spike count, or event flag in cascade mode |
| vld_o | output | 1 | Outputs hold a fresh step result |
| drive_o | output | IW | Inter-stage drive for the next stage, signed |

## Verification
The network is driven with five kinds of input:
- A constant moderate sample. This shows the staggered, inhibition-spaced firing order that depends on the unequal gains.
- A triangular varying term. Here the firing density must follow the input.
- A full-scale sample. This makes every cell fire in every step despite the inhibition, so the count reaches N.
- A long negative stretch followed by a positive one. The time each cell takes to recover separates a clamped state from a wrapped one.
- Cascade mode with the stage gain. This tells a single-event report apart from a plain count.

Idle cycles between steps show that held spikes still inhibit in the next real step. A reset in the middle of a run shows that no state is carried across it.

// File: rtl/ifn_pkg.sv
package ifn_pkg;

    // Gain of cell idx: spreads linearly from base to 1.5 * base.
    function automatic int unsigned cell_gain(input int unsigned idx,
                                              input int unsigned base,
                                              input int unsigned n);
        if (n < 2) return base;
        return base + (base * idx) / (2 * (n - 1));
    endfunction

endpackage

// File: rtl/ifn_popcnt.sv
module ifn_popcnt #(
    parameter int N  = 4,
    parameter int CW = 3
) (
    input  logic [N-1:0]  bits_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < N; i++) begin
            cnt_o = cnt_o + CW'(bits_i[i]);
        end
    end
endmodule

// File: rtl/ifn_cell.sv
module ifn_cell #(
    parameter int W    = 16,
    parameter int XW   = 9,
    parameter int CW   = 3,
    parameter int GAIN = 8,
    parameter int S    = 4,
    parameter int TH   = 1000,
    parameter int K    = 300
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step,
    input  logic signed [XW-1:0] x,
    input  logic [CW-1:0]        n_inh,
    output logic                 spk
);
    // Wide enough for leak, gain product and inhibition without overflow.
    localparam int AW = W + XW + CW + 8;
    localparam logic signed [AW-1:0] GAINV = AW'(GAIN);
    localparam logic signed [AW-1:0] KV    = AW'(K);
    localparam logic signed [AW-1:0] THV   = AW'(TH);
    localparam logic signed [AW-1:0] MINV  = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};

    typedef struct packed {
        logic signed [W-1:0] v;
        logic                spk;
    } cell_t;

    cell_t c_d, c_q;
    logic signed [AW-1:0] v_e, x_e, n_e, acc;

    always_comb begin
        c_d = c_q;
        v_e = {{(AW-W){c_q.v[W-1]}}, c_q.v};
        x_e = {{(AW-XW){x[XW-1]}}, x};
        n_e = {{(AW-CW){1'b0}}, n_inh};
        acc = v_e - (v_e >>> S) + x_e * GAINV - n_e * KV;
        if (step) begin
            if (acc >= THV) begin
                c_d.v   = '0;
                c_d.spk = 1'b1;
            end else if (acc < MINV) begin
                c_d.v   = MINV[W-1:0];
                c_d.spk = 1'b0;
            end else begin
                c_d.v   = acc[W-1:0];
                c_d.spk = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign spk = c_q.spk;
endmodule

// File: rtl/ifn_net.sv
module ifn_net #(
    parameter int N         = 4,
    parameter int W         = 16,
    parameter int IW        = 8,
    parameter int GAIN_BASE = 8,
    parameter int S         = 4,
    parameter int TH        = 1000,
    parameter int K         = 300
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step_i,
    input  logic signed [IW-1:0]         base_i,
    input  logic signed [IW-1:0]         var_i,
    input  logic                         casc_en_i,
    input  logic signed [IW-1:0]         stage_gain_i,
    output logic [N-1:0]                 spk_o,
    output logic [$clog2(N+1)-1:0]       cnt_o,
    output logic                         vld_o,
    output logic signed [IW-1:0]         drive_o
);
    localparam int XW = IW + 1;
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic vld;
    } net_t;

    net_t n_d, n_q;
    logic signed [XW-1:0] x_s;
    logic [N-1:0]         spk;
    logic [CW-1:0]        cnt;
    logic [CW-1:0]        others [N];

    assign x_s = {base_i[IW-1], base_i} + {var_i[IW-1], var_i};

    ifn_popcnt #(.N(N), .CW(CW)) u_cnt (
        .bits_i (spk),
        .cnt_o  (cnt)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        assign others[i] = cnt - CW'(spk[i]);
        ifn_cell #(
            .W    (W),
            .XW   (XW),
            .CW   (CW),
            .GAIN (int'(ifn_pkg::cell_gain(i, GAIN_BASE, N))),
            .S    (S),
            .TH   (TH),
            .K    (K)
        ) u_cell (
            .clk   (clk),
            .rst   (rst),
            .step  (step_i),
            .x     (x_s),
            .n_inh (others[i]),
            .spk   (spk[i])
        );
    end

    always_comb begin
        n_d     = n_q;
        n_d.vld = step_i;
    end

    always_ff @(posedge clk) begin
        if (rst) n_q <= '0;
        else     n_q <= n_d;
    end

    assign spk_o   = spk;
    assign vld_o   = n_q.vld;
    assign cnt_o   = casc_en_i ? CW'(|spk) : cnt;
    assign drive_o = (casc_en_i && (|spk)) ? stage_gain_i : '0;
endmodule

// File: rtl/ifn_net_chk.sv
module ifn_net_chk #(
    parameter int N  = 4,
    parameter int IW = 8,
    parameter int CW = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 step_i,
    input logic                 casc_en_i,
    input logic signed [IW-1:0] stage_gain_i,
    input logic [N-1:0]         spk_o,
    input logic [CW-1:0]        cnt_o,
    input logic                 vld_o,
    input logic signed [IW-1:0] drive_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (spk_o == '0 && !vld_o));

    a_r2_valid_after_step: assert property (@(posedge clk) disable iff (rst)
        step_i |=> vld_o);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> (!vld_o && $stable(spk_o)));

    a_r8_plain_count: assert property (@(posedge clk) disable iff (rst)
        !casc_en_i |-> (cnt_o == CW'($countones(spk_o)) && drive_o == '0));

    a_r9_event_count: assert property (@(posedge clk) disable iff (rst)
        casc_en_i |-> (cnt_o == CW'(spk_o != '0)));

    a_r9_event_drive: assert property (@(posedge clk) disable iff (rst)
        (casc_en_i && spk_o != '0) |-> (drive_o == stage_gain_i));

    a_r9_quiet_drive: assert property (@(posedge clk) disable iff (rst)
        (spk_o == '0) |-> (drive_o == '0));
endmodule

bind ifn_net ifn_net_chk #(.N(N), .IW(IW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .step_i       (step_i),
    .casc_en_i    (casc_en_i),
    .stage_gain_i (stage_gain_i),
    .spk_o        (spk_o),
    .cnt_o        (cnt_o),
    .vld_o        (vld_o),
    .drive_o      (drive_o)
);

// File: tb/ifn_net_tb.sv
module ifn_net_tb;
    localparam int N = 4, W = 16, IW = 8, GB = 8, S = 4, TH = 1000, K = 300;
    localparam int CW = $clog2(N + 1);
    localparam int MINV = -(1 << (W - 1));

    logic clk = 1'b0, rst = 1'b1, step_i = 1'b0, casc_en_i = 1'b0;
    logic signed [IW-1:0] base_i = '0, var_i = '0, stage_gain_i = '0;
    logic [N-1:0] spk_o;
    logic [CW-1:0] cnt_o;
    logic vld_o;
    logic signed [IW-1:0] drive_o;

    int n_chk = 0, n_fail = 0;
    int mv [N];
    int ms [N];

    typedef struct {
        logic [N-1:0] s;
        int c;
        int d;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    ifn_net #(.N(N), .W(W), .IW(IW), .GAIN_BASE(GB), .S(S), .TH(TH), .K(K)) u_dut (
        .clk(clk), .rst(rst), .step_i(step_i), .base_i(base_i), .var_i(var_i),
        .casc_en_i(casc_en_i), .stage_gain_i(stage_gain_i),
        .spk_o(spk_o), .cnt_o(cnt_o), .vld_o(vld_o), .drive_o(drive_o));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R7: gain spread from base to 1.5 * base.
    function automatic int gain(input int i);
        return GB + (GB * i) / (2 * (N - 1));
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        step_i = 1'b0;
        for (int i = 0; i < N; i++) begin mv[i] = 0; ms[i] = 0; end
        repeat (3) @(negedge clk);
        chk(spk_o == '0, "R1 spikes", int'(spk_o), 0);
        chk(vld_o == 1'b0 && cnt_o == '0, "R1 valid/count", int'(cnt_o), 0);
        chk(drive_o == '0, "R1 drive", int'(drive_o), 0);
        rst = 1'b0;
    endtask

    // Driver: applies one step and pushes the expected result (R3 R4 R5 R6).
    task automatic do_step(input int b, input int va);
        int x, prev, acc;
        int nv [N];
        int ns [N];
        exp_t e;
        x = b + va;
        prev = 0;
        for (int i = 0; i < N; i++) prev += ms[i];
        e.s = '0;
        e.c = 0;
        for (int i = 0; i < N; i++) begin
            acc = mv[i] - (mv[i] >>> S) + gain(i) * x - K * (prev - ms[i]);
            if (acc >= TH) begin nv[i] = 0; ns[i] = 1; end
            else if (acc < MINV) begin nv[i] = MINV; ns[i] = 0; end
            else begin nv[i] = acc; ns[i] = 0; end
        end
        for (int i = 0; i < N; i++) begin
            mv[i] = nv[i];
            ms[i] = ns[i];
            e.s[i] = ns[i][0];
            e.c += ns[i];
        end
        e.d = 0;
        if (casc_en_i) begin
            e.c = (e.c != 0) ? 1 : 0;
            e.d = (e.c != 0) ? int'(stage_gain_i) : 0;
        end
        q.push_back(e);
        step_i = 1'b1;
        base_i = IW'(b);
        var_i  = IW'(va);
        @(negedge clk);
        step_i = 1'b0;
    endtask

    // Monitor: compares each fresh result with the scoreboard.
    always @(negedge clk) begin
        if (!rst && vld_o) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2 unexpected valid", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(spk_o == e.s, "R3 R4 R5 R6 R7 spike vector", int'(spk_o), int'(e.s));
                chk(int'(cnt_o) == e.c, "R8 R9 count", int'(cnt_o), e.c);
                chk(int'(drive_o) == e.d, "R8 R9 drive", int'(drive_o), e.d);
            end
        end
    end

    task automatic drain();
        repeat (2) @(negedge clk);
        chk(q.size() == 0, "R2 missing results", q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [N-1:0] held;
        @(negedge clk);
        do_reset();

        // Constant moderate input: staggered firing (R3 R4 R5 R7 R8).
        for (int t = 0; t < 30; t++) do_step(40, 10);

        // Idle cycles hold state, and held spikes inhibit the next step (R2).
        held = spk_o;
        repeat (3) begin
            @(negedge clk);
            chk(vld_o == 1'b0, "R2 idle valid", int'(vld_o), 0);
            chk(spk_o == held, "R2 idle hold", int'(spk_o), int'(held));
        end
        for (int t = 0; t < 10; t++) do_step(40, 10);

        // Triangular varying term.
        for (int t = 0; t < 40; t++) do_step(30, (t % 20 < 10) ? (t % 10) * 8 : 80 - (t % 10) * 8);

        // Full scale: every cell fires every step, count reaches N.
        for (int t = 0; t < 6; t++) do_step(127, 127);

        // Deep negative stretch, then recovery (R6).
        for (int t = 0; t < 25; t++) do_step(-128, -128);
        for (int t = 0; t < 40; t++) do_step(100, 20);
        drain();

        // Cascade mode with an inter-stage gain (R9).
        casc_en_i = 1'b1;
        stage_gain_i = 8'sd77;
        @(negedge clk);
        for (int t = 0; t < 20; t++) do_step(60, 30);
        for (int t = 0; t < 4; t++) do_step(0, 0);
        stage_gain_i = -8'sd50;
        @(negedge clk);
        for (int t = 0; t < 10; t++) do_step(127, 127);
        drain();
        casc_en_i = 1'b0;
        stage_gain_i = '0;

        // Reset in mid-run, then fresh behaviour (R1 R2).
        for (int t = 0; t < 5; t++) do_step(50, 0);
        drain();
        do_reset();
        for (int t = 0; t < 15; t++) do_step(70, -10);
        drain();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule